// File: doc/BRIEF.md
# Boot ROM Window Chip-Select Decoder

This block produces the active-low select for an optional boot ROM that sits in a 20-bit host memory space. Software programs a window base and a window size mask through a small 16-bit register write port. Each 20-bit register is written as two words: a low word carrying bits 15:0 and a high word whose bits 3:0 land in bits 19:16. The decoder then watches the host address bus. It pulls the chip-select low while a memory read is in progress, no DMA cycle owns the bus, and the masked address equals the masked base.

The mask works in 4 KB units. Its twelve least significant bits are always zero, whatever is written to them. For safety the decoder stays disarmed until each of the two registers has received at least one write, to either of its words. The chip-select is combinational from the address and strobes, so it settles in the same cycle as the address. A second active-low output copies it to enable an external data buffer.

Top module: `bootrom_window_dec`

## Requirements
- R1: A synchronous reset clears base, mask and both loaded flags, so after reset both select outputs are high (1) for any address and strobe.
- R2: A write strobe with word offset 30h loads base bits 15:0 from the write data. Offset 32h loads base bits 19:16 from write data bits 3:0. Data bits 15:4 of a high-word write are discarded.
- R3: Offset 34h loads mask bits 15:0 and offset 36h loads mask bits 19:16 from data bits 3:0. Data bits 15:4 of a high-word write are discarded.
- R4: Mask bits 11:0 always read as zero, so address bits 11:0 never affect the decode.
- R5: A write to either word of a register sets that register's loaded flag. The chip-select stays high until both flags are set. A register that was loaded with all zeros still counts as loaded.
- R6: Once armed, with the read strobe high and the DMA address-enable low, the chip-select is low exactly when (address AND mask) equals (base AND mask).
- R7: The chip-select is high whenever the read strobe is low or the DMA address-enable is high.
- R8: Writes with any other word offset, and any offset presented without the write strobe, change neither register nor flag.
- R9: The buffer-enable output always carries the same value as the chip-select.
- R10: The chip-select follows a change of address or strobes within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_off | input | 8 | Word offset of the register write |
| cfg_wdata | input | 16 | Register write data |
| host_addr | input | 20 | Host memory address |
| host_mem_rd | input | 1 | Host memory read strobe, active high |
| host_aen | input | 1 | DMA address-enable, high while DMA owns the bus |
| rom_cs_n | output | 1 | Boot ROM chip-select, active low |
| rom_buf_en_n | output | 1 | External data buffer enable, active low |

## Verification
The hardest situation to reach is the half-armed state, where only one register has been loaded, while the loaded register's value would already let every address match. The stimulus writes only the base low word first. It then writes only the mask high word with zero. That gives an all-zero mask, which would select any address the moment the block arms, so the first check shows the disarm rule holding and the second shows one word being enough to arm. The masked-compare vectors use garbage in the mask low bits and in the discarded high-word bits, so a design that kept either set of bits would decode the wrong window.

// File: rtl/bootrom_dec_pkg.sv
package bootrom_dec_pkg;
  localparam int unsigned BR_ADDR_W    = 20;
  localparam int unsigned BR_DATA_W    = 16;
  localparam int unsigned BR_OFF_W     = 8;
  localparam int unsigned BR_GRAN_BITS = 12;

  // Word offsets of the two halves of each register.
  localparam logic [BR_OFF_W-1:0] BR_BASE_LO_OFF = 8'h30;
  localparam logic [BR_OFF_W-1:0] BR_BASE_HI_OFF = 8'h32;
  localparam logic [BR_OFF_W-1:0] BR_MASK_LO_OFF = 8'h34;
  localparam logic [BR_OFF_W-1:0] BR_MASK_HI_OFF = 8'h36;

  localparam int unsigned BR_NUM_REGS = 2;
  localparam int unsigned BR_IDX_BASE = 0;
  localparam int unsigned BR_IDX_MASK = 1;
endpackage

// File: rtl/bootrom_split_reg.sv
module bootrom_split_reg #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OFF_W   = 8,
  parameter logic [OFF_W-1:0] LO_OFF = '0,
  parameter logic [OFF_W-1:0] HI_OFF = '0,
  parameter int unsigned CLR_LSB = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] value_q,
  output logic              loaded_q
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << CLR_LSB;

  logic hit_lo;
  logic hit_hi;

  assign hit_lo = wr && (off == LO_OFF);
  assign hit_hi = wr && (off == HI_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q  <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (hit_lo) begin
        value_q[DATA_W-1:0] <= wdata & KEEP[DATA_W-1:0];
        loaded_q            <= 1'b1;
      end else if (hit_hi) begin
        value_q[ADDR_W-1:DATA_W] <= HI_W'(wdata) & KEEP[ADDR_W-1:DATA_W];
        loaded_q                 <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bootrom_win_match.sv
module bootrom_win_match #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              armed,
  input  logic              mem_rd,
  input  logic              dma_aen,
  output logic              hit
);
  logic addr_eq;

  always_comb begin
    addr_eq = ((addr & mask) == (base & mask));
    hit     = armed && mem_rd && !dma_aen && addr_eq;
  end
endmodule

// File: rtl/bootrom_window_dec.sv
module bootrom_window_dec
  import bootrom_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = BR_ADDR_W,
  parameter int unsigned DATA_W    = BR_DATA_W,
  parameter int unsigned OFF_W     = BR_OFF_W,
  parameter int unsigned GRAN_BITS = BR_GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_mem_rd,
  input  logic              host_aen,
  output logic              rom_cs_n,
  output logic              rom_buf_en_n
);
  logic [ADDR_W-1:0] reg_val [BR_NUM_REGS];
  logic              reg_ld  [BR_NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < BR_NUM_REGS; g++) begin : g_reg
      localparam bit IS_MASK = (g == BR_IDX_MASK);
      bootrom_split_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .LO_OFF (IS_MASK ? BR_MASK_LO_OFF : BR_BASE_LO_OFF),
        .HI_OFF (IS_MASK ? BR_MASK_HI_OFF : BR_BASE_HI_OFF),
        .CLR_LSB(IS_MASK ? GRAN_BITS : 0)
      ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .off     (cfg_off),
        .wdata   (cfg_wdata),
        .value_q (reg_val[g]),
        .loaded_q(reg_ld[g])
      );
    end
  endgenerate

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] mask_q;
  logic              base_ld;
  logic              mask_ld;
  logic              armed;
  logic              win_hit;

  assign base_q  = reg_val[BR_IDX_BASE];
  assign mask_q  = reg_val[BR_IDX_MASK];
  assign base_ld = reg_ld[BR_IDX_BASE];
  assign mask_ld = reg_ld[BR_IDX_MASK];
  assign armed   = base_ld && mask_ld;

  bootrom_win_match #(.ADDR_W(ADDR_W)) u_match (
    .addr   (host_addr),
    .base   (base_q),
    .mask   (mask_q),
    .armed  (armed),
    .mem_rd (host_mem_rd),
    .dma_aen(host_aen),
    .hit    (win_hit)
  );

  assign rom_cs_n     = ~win_hit;
  assign rom_buf_en_n = ~win_hit;
endmodule

// File: rtl/bootrom_window_dec_chk.sv
module bootrom_window_dec_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFF_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [OFF_W-1:0]  cfg_off,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_mem_rd,
  input logic              host_aen,
  input logic              rom_cs_n,
  input logic              rom_buf_en_n,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] mask_q,
  input logic              base_ld,
  input logic              mask_ld
);
  logic known_off;
  assign known_off = (cfg_off == 8'h30) || (cfg_off == 8'h32) ||
                     (cfg_off == 8'h34) || (cfg_off == 8'h36);

  AST_BASE_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_off == 8'h30) |=> (base_q[DATA_W-1:0] == $past(cfg_wdata))); // R2

  AST_MASK_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    $changed(mask_q) |-> (mask_q[11:0] == 12'h000)); // R4

  AST_CS_NEEDS_ARMED: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> (base_ld && mask_ld)); // R5

  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (rst)
    (base_ld && mask_ld) |=> (base_ld && mask_ld)); // R5

  AST_CS_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> ((host_addr & mask_q) == (base_q & mask_q))); // R6

  AST_CS_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> (host_mem_rd && !host_aen)); // R7

  AST_STRAY_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wr || !known_off) |=> ($stable(base_q) && $stable(mask_q))); // R8

  AST_BUF_MATCHES_CS: assert property (@(posedge clk) disable iff (rst)
    rom_buf_en_n == rom_cs_n); // R9
endmodule

bind bootrom_window_dec bootrom_window_dec_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr      (cfg_wr),
  .cfg_off     (cfg_off),
  .cfg_wdata   (cfg_wdata),
  .host_addr   (host_addr),
  .host_mem_rd (host_mem_rd),
  .host_aen    (host_aen),
  .rom_cs_n    (rom_cs_n),
  .rom_buf_en_n(rom_buf_en_n),
  .base_q      (base_q),
  .mask_q      (mask_q),
  .base_ld     (base_ld),
  .mask_ld     (mask_ld)
);

// File: tb/tb_bootrom_window_dec.sv
module tb_bootrom_window_dec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [15:0] cfg_wdata = '0;
  logic [19:0] host_addr = '0;
  logic        host_mem_rd = 1'b0;
  logic        host_aen = 1'b0;
  logic        rom_cs_n;
  logic        rom_buf_en_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  bootrom_window_dec dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .host_addr(host_addr), .host_mem_rd(host_mem_rd),
    .host_aen(host_aen), .rom_cs_n(rom_cs_n), .rom_buf_en_n(rom_buf_en_n)
  );

  // {addr, rd, aen, expected cs_n}; window is 0D0000h-0D3FFFh
  localparam logic [22:0] VEC [8] = '{
    {20'hD0000, 1'b1, 1'b0, 1'b0},
    {20'hD3FFF, 1'b1, 1'b0, 1'b0},
    {20'hD4000, 1'b1, 1'b0, 1'b1},
    {20'hCFFFF, 1'b1, 1'b0, 1'b1},
    {20'hD2345, 1'b0, 1'b0, 1'b1},
    {20'hD2345, 1'b1, 1'b1, 1'b1},
    {20'h50000, 1'b1, 1'b0, 1'b1},
    {20'hD0FFF, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] off, input logic [15:0] data,
                           input logic strobe);
    @(negedge clk);
    cfg_wr = strobe; cfg_off = off; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_off = 8'h00; cfg_wdata = 16'h0000;
  endtask

  task automatic probe(input logic [19:0] a, input logic rd, input logic aen,
                       input logic exp, input string req);
    host_addr = a; host_mem_rd = rd; host_aen = aen;
    #1;
    check(req, rom_cs_n, exp);
    check("R9 buffer enable", rom_buf_en_n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: after reset nothing decodes
    probe(20'h00000, 1'b1, 1'b0, 1'b1, "R1 reset state");
    // R5: base only -> still disarmed
    reg_write(8'h30, 16'h0000, 1'b1);
    probe(20'h00000, 1'b1, 1'b0, 1'b1, "R5 base only");
    // R5: mask high word alone arms; zero mask matches all
    reg_write(8'h36, 16'h0000, 1'b1);
    probe(20'h12345, 1'b1, 1'b0, 1'b0, "R5 armed by one word");
    // R2/R3: program window, garbage in discarded and masked bits
    reg_write(8'h32, 16'hABCD, 1'b1);
    reg_write(8'h34, 16'hC123, 1'b1);
    reg_write(8'h36, 16'hFFFF, 1'b1);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      probe(VEC[i][22:3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R6 R7 R2 R3 vector %0d", i));
    end
    // R4: low address bits ignored although 123h was written to mask
    probe(20'hD0123, 1'b1, 1'b0, 1'b0, "R4 mask low bits");
    // R10: address change without clock edge
    @(posedge clk); #2;
    probe(20'hD4000, 1'b1, 1'b0, 1'b1, "R10 same-cycle deassert");
    probe(20'hD1000, 1'b1, 1'b0, 1'b0, "R10 same-cycle assert");
    // R8: stray offsets and unstrobed writes
    reg_write(8'h31, 16'h4000, 1'b1);
    reg_write(8'h38, 16'h0000, 1'b1);
    reg_write(8'h30, 16'h4000, 1'b0);
    reg_write(8'h34, 16'h0000, 1'b0);
    probe(20'hD0000, 1'b1, 1'b0, 1'b0, "R8 window kept");
    probe(20'hD4000, 1'b1, 1'b0, 1'b1, "R8 mask kept");
    // R1: reset mid-run disarms
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    probe(20'hD0000, 1'b1, 1'b0, 1'b1, "R1 reset disarms");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule